// File: doc/BRIEF.md
# ADC Result Computation Unit

This block sits behind an analog-to-digital converter and turns its stream of 10-bit conversion results into a processed result. It asks the converter for conversions through a one-cycle request strobe and receives each finished conversion as a data word with a valid strobe. Four selectable modes decide what happens to each sample. The sample can be passed straight through. Samples can be summed over several triggers and averaged. A single trigger can fire a back-to-back burst of conversions that is then averaged. Or each sample can be fed through a first-order low-pass filter whose cut-off is set by a shift amount.

Every result the block produces is also judged against a programmable setpoint. The signed error, result minus setpoint, is compared with a signed lower and upper limit. An error strictly inside the window gives a one-cycle threshold interrupt. An error outside it gives a one-cycle error flag. Both are aligned with the result-valid strobe.

Top module: `adc_compute`

## Requirements
- R1: In mode 0 (basic), every valid sample appears unchanged on `result`, with `resultValid` high for one cycle, one clock after the sample strobe.
- R2: In modes 0, 1 and 3, each clock with `trigger` high gives exactly one `convStart` pulse on the following cycle.
- R3: In mode 1 (average), each sample is added to a sum. After the repeat-count-th sample, `result` = sum >> `shiftAmt`, saturated to 1023. No `resultValid` is raised for the earlier samples, and the sum restarts from zero.
- R4: In mode 2 (burst), a trigger while idle raises `convStart`. Every sample of the burst except the last raises `convStart` again. So one trigger yields exactly repeat-count requests, and the burst's average is formed as in R3.
- R5: In mode 2, a trigger that arrives during a burst does not raise `convStart`, and a sample that arrives while no burst is running gives no result.
- R6: A repeat count of 0 behaves as a repeat count of 1.
- R7: In mode 3 (low-pass), the filter state F holds 1/256-LSB units and is 0 after reset. Each sample d sets F to F + floor((256*d - F) / 2^shiftAmt), and `result` = floor(F/256), one result per sample.
- R8: For every result, err = result - setpoint. `thrIrq` pulses when lowThr < err < highThr (strict, signed). Otherwise `errFlag` pulses. Neither is raised without `resultValid`, and never both at once.
- R9: A change of `mode` clears any partial sum, sample count and running burst. A sample in the cycle of the change is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigger | input | 1 | Conversion trigger |
| sampleValid | input | 1 | Conversion result strobe |
| sampleData | input | 10 | Conversion result |
| mode | input | 2 | 0 basic, 1 average, 2 burst, 3 low-pass |
| rptCount | input | 5 | Samples per average |
| shiftAmt | input | 3 | Average shift / filter shift |
| setpoint | input | 10 | Setpoint for the error |
| lowThr | input | 12 | Signed lower error limit |
| highThr | input | 12 | Signed upper error limit |
| convStart | output | 1 | Request one conversion |
| result | output | 10 | Computed result |
| resultValid | output | 1 | Result strobe |
| thrIrq | output | 1 | Error inside window |
| errFlag | output | 1 | Error outside window |

## Verification
In burst mode, the last sample of a burst, which closes the average, can fall in the same cycle as a new trigger. A trigger can also arrive while the burst is still requesting conversions. The bench provokes the second case by raising a stray trigger between two burst samples. It judges the outcome by counting `convStart` pulses per burst against the repeat count and checking that the averaged result is unaffected. The window comparison shares its cycle with every result, so the bench sweeps all 1024 codes in basic mode, including the exact window edges, and checks the interrupt and the flag on each.

// File: rtl/adc_compute_pkg.sv
package adc_compute_pkg;
  typedef enum logic [1:0] {
    MODE_BASIC = 2'd0,
    MODE_AVG   = 2'd1,
    MODE_BURST = 2'd2,
    MODE_LPF   = 2'd3
  } mode_e;

  typedef struct packed {
    logic passSample;
    logic accumSample;
    logic finishAvg;
    logic filterSample;
    logic clearAcc;
  } ctrl_t;
endpackage

// File: rtl/adc_compute_ctrl.sv
module adc_compute_ctrl
  import adc_compute_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigger,
  input  logic             sampleValid,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] rptCount,
  output ctrl_t            ctl,
  output logic             convStart
);
  mode_e modeNow, modeQ;
  logic [CNT_W-1:0] cntQ, rptEff;
  logic busyQ, convStartQ, modeChange, lastSample;

  assign modeNow    = mode_e'(mode);
  assign modeChange = (modeNow != modeQ);
  assign rptEff     = (rptCount == '0) ? CNT_W'(1) : rptCount;
  assign lastSample = ({1'b0, cntQ} + 1'b1) >= {1'b0, rptEff};
  assign convStart  = convStartQ;

  always_comb begin
    ctl = '0;
    ctl.clearAcc = modeChange;
    if (!modeChange && sampleValid) begin
      unique case (modeNow)
        MODE_BASIC: ctl.passSample = 1'b1;
        MODE_AVG: begin
          ctl.finishAvg   = lastSample;
          ctl.accumSample = !lastSample;
        end
        MODE_BURST: begin
          ctl.finishAvg   = busyQ && lastSample;
          ctl.accumSample = busyQ && !lastSample;
        end
        MODE_LPF: ctl.filterSample = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= MODE_BASIC;
      cntQ       <= '0;
      busyQ      <= 1'b0;
      convStartQ <= 1'b0;
    end else begin
      modeQ <= modeNow;
      if (modeChange) begin
        cntQ       <= '0;
        busyQ      <= 1'b0;
        convStartQ <= 1'b0;
      end else begin
        if (ctl.finishAvg)        cntQ <= '0;
        else if (ctl.accumSample) cntQ <= cntQ + 1'b1;
        if (modeNow == MODE_BURST) begin
          if (!busyQ && trigger) begin
            busyQ      <= 1'b1;
            convStartQ <= 1'b1;
          end else begin
            convStartQ <= busyQ && ctl.accumSample;
            if (ctl.finishAvg) busyQ <= 1'b0;
          end
        end else begin
          busyQ      <= 1'b0;
          convStartQ <= trigger;
        end
      end
    end
  end

  // Strobes to the datapath are mutually exclusive (R3, R7, R9)
  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.passSample, ctl.accumSample, ctl.finishAvg, ctl.filterSample, ctl.clearAcc}));

  // A trigger during a running burst requests nothing (R5)
  assert_burst_trigger_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == MODE_BURST && !modeChange && busyQ && trigger && !sampleValid) |=> !convStart);

  // Closing a burst returns to idle (R4)
  assert_burst_closes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finishAvg && modeNow == MODE_BURST) |=> !busyQ);
endmodule

// File: rtl/adc_compute_dp.sv
module adc_compute_dp
  import adc_compute_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int CNT_W   = 5,
  parameter int SHIFT_W = 3,
  parameter int GUARD   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_t                    ctl,
  input  logic [DATA_W-1:0]        sampleData,
  input  logic [SHIFT_W-1:0]       shiftAmt,
  input  logic [DATA_W-1:0]        setpoint,
  input  logic signed [DATA_W+1:0] lowThr,
  input  logic signed [DATA_W+1:0] highThr,
  output logic [DATA_W-1:0]        result,
  output logic                     resultValid,
  output logic                     thrIrq,
  output logic                     errFlag
);
  localparam int ACC_W = DATA_W + CNT_W;
  localparam int FW    = DATA_W + GUARD + 1;

  logic [ACC_W-1:0] accQ, sumNext, avgShift;
  logic [DATA_W-1:0] avgSat, newResult;
  logic signed [FW-1:0] filtQ, filtNext;
  logic signed [FW:0] diff, step;
  logic signed [DATA_W+1:0] errVal;
  logic newValid, inWin;

  assign sumNext  = accQ + ACC_W'(sampleData);
  assign avgShift = sumNext >> shiftAmt;
  assign avgSat   = (|avgShift[ACC_W-1:DATA_W]) ? {DATA_W{1'b1}} : avgShift[DATA_W-1:0];

  assign diff     = $signed({2'b00, sampleData, {GUARD{1'b0}}}) - $signed({filtQ[FW-1], filtQ});
  assign step     = diff >>> shiftAmt;
  assign filtNext = filtQ + step[FW-1:0];

  always_comb begin
    newValid  = ctl.passSample | ctl.finishAvg | ctl.filterSample;
    newResult = sampleData;
    if (ctl.finishAvg)         newResult = avgSat;
    else if (ctl.filterSample) newResult = filtNext[GUARD +: DATA_W];
  end

  assign errVal = $signed({2'b00, newResult}) - $signed({2'b00, setpoint});
  assign inWin  = (errVal > lowThr) && (errVal < highThr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ        <= '0;
      filtQ       <= '0;
      result      <= '0;
      resultValid <= 1'b0;
      thrIrq      <= 1'b0;
      errFlag     <= 1'b0;
    end else begin
      if (ctl.clearAcc || ctl.finishAvg) accQ <= '0;
      else if (ctl.accumSample)          accQ <= sumNext;
      if (ctl.filterSample) filtQ <= filtNext;
      resultValid <= newValid;
      if (newValid) result <= newResult;
      thrIrq  <= newValid && inWin;
      errFlag <= newValid && !inWin;
    end
  end

  // Comparison pulses never coincide (R8)
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(thrIrq && errFlag));

  // Comparison pulses only ride on a result (R8)
  assert_flags_with_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (thrIrq || errFlag) |-> resultValid);

  // Basic mode forwards the sample unchanged (R1)
  assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.passSample |=> (resultValid && result == $past(sampleData)));
endmodule

// File: rtl/adc_compute.sv
module adc_compute
  import adc_compute_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int CNT_W   = 5,
  parameter int SHIFT_W = 3,
  parameter int GUARD   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     trigger,
  input  logic                     sampleValid,
  input  logic [DATA_W-1:0]        sampleData,
  input  logic [1:0]               mode,
  input  logic [CNT_W-1:0]         rptCount,
  input  logic [SHIFT_W-1:0]       shiftAmt,
  input  logic [DATA_W-1:0]        setpoint,
  input  logic signed [DATA_W+1:0] lowThr,
  input  logic signed [DATA_W+1:0] highThr,
  output logic                     convStart,
  output logic [DATA_W-1:0]        result,
  output logic                     resultValid,
  output logic                     thrIrq,
  output logic                     errFlag
);
  ctrl_t ctl;

  adc_compute_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .sampleValid(sampleValid),
    .mode(mode), .rptCount(rptCount), .ctl(ctl), .convStart(convStart)
  );

  adc_compute_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .GUARD(GUARD)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleData(sampleData), .shiftAmt(shiftAmt),
    .setpoint(setpoint), .lowThr(lowThr), .highThr(highThr), .result(result),
    .resultValid(resultValid), .thrIrq(thrIrq), .errFlag(errFlag)
  );
endmodule

// File: tb/adc_compute_bench.sv
module adc_compute_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigger = 1'b0;
  logic sampleValid = 1'b0;
  logic [9:0] sampleData = '0;
  logic [1:0] mode = 2'd0;
  logic [4:0] rptCount = 5'd16;
  logic [2:0] shiftAmt = 3'd4;
  logic [9:0] setpoint = 10'd511;
  logic signed [11:0] lowThr = -12'sd200;
  logic signed [11:0] highThr = 12'sd200;
  logic convStart, resultValid, thrIrq, errFlag;
  logic [9:0] result;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_compute u_adc_compute (
    .clk(clk), .rstN(rstN), .trigger(trigger), .sampleValid(sampleValid),
    .sampleData(sampleData), .mode(mode), .rptCount(rptCount), .shiftAmt(shiftAmt),
    .setpoint(setpoint), .lowThr(lowThr), .highThr(highThr), .convStart(convStart),
    .result(result), .resultValid(resultValid), .thrIrq(thrIrq), .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendSample(input int d);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = 10'(d);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic checkOut(input string req, input int expR);
    int e;
    bit w;
    e = expR - 511;
    w = (e > -200) && (e < 200);
    check(resultValid == 1'b1, req, resultValid, 1);
    check(result == 10'(expR), req, result, expR);
    check(thrIrq == w, "R8", thrIrq, w);
    check(errFlag == !w, "R8", errFlag, !w);
  endtask

  task automatic setMode(input int m);
    @(negedge clk);
    mode = 2'(m);
    repeat (2) @(negedge clk);
  endtask

  task automatic runBurst(input int base, input int rpt, input int sh);
    int sum = 0;
    int reqs = 0;
    int w;
    int d;
    int ex;
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    for (int k = 0; k < rpt; k++) begin
      w = 0;
      while (!convStart && w < 10) begin
        @(negedge clk);
        w++;
      end
      check(convStart == 1'b1, "R4", convStart, 1);
      reqs++;
      if (k == 1) begin
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        check(convStart == 1'b0, "R5", convStart, 0);
      end
      d = (base + k * 97) % 1024;
      sum += d;
      sendSample(d);
      if (k < rpt - 1) check(resultValid == 1'b0, "R4", resultValid, 0);
      else begin
        ex = sum >> sh;
        if (ex > 1023) ex = 1023;
        checkOut("R4", ex);
      end
    end
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      if (convStart) reqs++;
    end
    check(reqs == rpt, "R4", reqs, rpt);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int sum;
    int d;
    int f;
    int ex;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(resultValid == 0 && thrIrq == 0 && errFlag == 0, "R1", resultValid, 0);
    check(convStart == 0 && result == 0, "R2", convStart, 0);

    // R1 / R8: full sweep in basic mode, includes window edges 311/312/710/711
    for (int v = 0; v < 1024; v++) begin
      sendSample(v);
      checkOut("R1", v);
    end

    // R2: trigger to request, basic mode
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    check(convStart == 1'b1, "R2", convStart, 1);
    @(negedge clk);
    check(convStart == 1'b0, "R2", convStart, 0);

    // R3: average mode, repeat 16, shift 4
    rptCount = 5'd16; shiftAmt = 3'd4;
    setMode(1);
    for (int s = 0; s < 3; s++) begin
      sum = 0;
      for (int k = 0; k < 16; k++) begin
        d = (s * 311 + k * 53) % 1024;
        sum += d;
        sendSample(d);
        if (k < 15) check(resultValid == 1'b0, "R3", resultValid, 0);
        else checkOut("R3", sum >> 4);
      end
    end
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    check(convStart == 1'b1, "R2", convStart, 1);

    // R3 saturation and plain case with repeat 4, shift 1
    rptCount = 5'd4; shiftAmt = 3'd1;
    for (int k = 0; k < 4; k++) sendSample(1000);
    checkOut("R3", 1023);
    for (int k = 0; k < 4; k++) sendSample(200);
    checkOut("R3", 400);

    // R6: repeat 0 acts as 1
    rptCount = 5'd0; shiftAmt = 3'd0;
    sendSample(700);
    checkOut("R6", 700);
    sendSample(100);
    checkOut("R6", 100);

    // R9: mode change discards a partial sum
    rptCount = 5'd4; shiftAmt = 3'd2;
    sendSample(900);
    sendSample(900);
    setMode(0);
    setMode(1);
    for (int k = 0; k < 4; k++) begin
      sendSample(100);
      if (k < 3) check(resultValid == 1'b0, "R9", resultValid, 0);
    end
    checkOut("R9", 100);

    // R4 / R5: burst mode
    rptCount = 5'd8; shiftAmt = 3'd3;
    setMode(2);
    sendSample(555);
    check(resultValid == 1'b0, "R5", resultValid, 0);
    check(convStart == 1'b0, "R5", convStart, 0);
    runBurst(40, 8, 3);
    runBurst(500, 8, 3);

    // R7: low-pass, step up then down
    shiftAmt = 3'd3;
    setMode(3);
    f = 0;
    for (int k = 0; k < 60; k++) begin
      d = (k < 40) ? 800 : 100;
      f = f + ((d * 256 - f) >>> 3);
      ex = f >>> 8;
      sendSample(d);
      checkOut("R7", ex);
    end
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    check(convStart == 1'b1, "R2", convStart, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule